// File: doc/BRIEF.md
# Power Management Clock Divider

This block produces the machine-cycle enable that paces a CPU core. At full speed every input clock is a machine cycle and the enable stays high. In power-management mode the enable becomes a single-clock pulse once every 1024 input clocks, so the core advances at a fraction of its normal rate while the clock itself keeps running.

Software selects the speed by writing a control bit through a write strobe and data bit, and can read the bit back. A hardware switchback path, when enabled, watches an interrupt-pending line. Once an interrupt is pending it clears the control bit, and the core returns to full speed without any software action. Every speed change, whether software or hardware asked for it, waits for the end of the current machine cycle, so a slow cycle is never cut short.

Top module: `pm_clkdiv`

## Requirements
- R1: While reset is asserted, `cyc_en_o` is 1, `slow_o` is 0 and `pm_ctrl_o` is 0.
- R2: While `slow_o` is 0, `cyc_en_o` is 1 on every clock.
- R3: While `slow_o` is 1, `cyc_en_o` is a one-clock pulse followed by exactly DIV_RATIO-1 low clocks (DIV_RATIO defaults to 1024).
- R4: A write of 1 (`pm_wr_i`=1, `pm_wdata_i`=1) sets `pm_ctrl_o` on the next clock. When the block is at full speed, `slow_o` rises one clock after that, and the first pulse follows after DIV_RATIO-1 low clocks.
- R5: A write of 0 while slow clears `pm_ctrl_o` on the next clock. `slow_o` stays 1 through the pulse that ends the current slow cycle and falls on the clock after that pulse.
- R6: With `swb_en_i`=1 and `irq_pend_i`=1, `pm_ctrl_o` is 0 on the next clock. A slow block returns to full speed on the clock after the pulse that ends its current slow cycle.
- R7: With `swb_en_i`=0, `irq_pend_i` has no effect: `pm_ctrl_o` stays 1, `slow_o` stays 1 and the pulse spacing is unchanged.
- R8: A write of 1 during an active switchback condition leaves `pm_ctrl_o` at 0, and the block stays at full speed.
- R9: `slow_o` changes only on the clock right after a clock in which `cyc_en_o` was 1. A mode write made in the middle of a slow cycle does not shorten that cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Input clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| pm_wr_i | input | 1 | Write strobe for the speed control bit |
| pm_wdata_i | input | 1 | Value written: 1 requests slow mode, 0 requests full speed |
| swb_en_i | input | 1 | Enables hardware switchback on a pending interrupt |
| irq_pend_i | input | 1 | An enabled interrupt is pending |
| cyc_en_o | output | 1 | Machine-cycle enable |
| slow_o | output | 1 | Current speed: 1 while in power-management mode |
| pm_ctrl_o | output | 1 | Readback of the speed control bit |

## Verification
The assertions check on every clock that full speed always enables, that a slow pulse is never followed at once by another slow pulse, that the speed changes only after an enable, that slow mode is entered only while the control bit is set, and that switchback clears the bit and blocks entry. Only the bench scenarios can show the exact 1024-clock spacing, the readback after writes, and where a mid-cycle software exit or switchback falls in time. They also show that a pending interrupt with switchback disabled changes nothing.

// File: rtl/pm_clkdiv_pkg.sv
package pm_clkdiv_pkg;
  typedef enum logic {
    SPEED_FULL = 1'b0,
    SPEED_SLOW = 1'b1
  } speed_e;
endpackage

// File: rtl/pm_clkdiv_rstsync.sv
module pm_clkdiv_rstsync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic arst_ni,
  output logic srst_no
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk_i or negedge arst_ni) begin
    if (!arst_ni) sync_q <= '0;
    else          sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign srst_no = sync_q[STAGES-1];
endmodule

// File: rtl/pm_clkdiv_ctrl.sv
module pm_clkdiv_ctrl (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic wr_i,
  input  logic wdata_i,
  input  logic swb_hit_i,
  output logic ctrl_o
);
  logic ctrl_q, ctrl_d, ctrl_en;

  // Switchback overrides a software write in the same clock.
  always_comb begin
    ctrl_en = wr_i | swb_hit_i;
    ctrl_d  = ctrl_q;
    if (wr_i)      ctrl_d = wdata_i;
    if (swb_hit_i) ctrl_d = 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      ctrl_q <= 1'b0;
    else if (ctrl_en) ctrl_q <= ctrl_d;
  end

  assign ctrl_o = ctrl_q;
endmodule

// File: rtl/pm_clkdiv_cnt.sv
module pm_clkdiv_cnt #(
  parameter int DIV_RATIO = 1024
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic tick_o
);
  localparam int CNT_W = (DIV_RATIO > 1) ? $clog2(DIV_RATIO) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(DIV_RATIO - 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  always_comb begin
    tick_o = !run_i || (cnt_q == LAST);
    cnt_d  = (run_i && !tick_o) ? cnt_q + 1'b1 : '0;
    cnt_en = run_i || (cnt_q != '0);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end
endmodule

// File: rtl/pm_clkdiv_mode.sv
module pm_clkdiv_mode
  import pm_clkdiv_pkg::*;
(
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   boundary_i,
  input  logic   want_slow_i,
  output speed_e speed_o
);
  speed_e speed_q, speed_d;

  always_comb begin
    speed_d = want_slow_i ? SPEED_SLOW : SPEED_FULL;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         speed_q <= SPEED_FULL;
    else if (boundary_i) speed_q <= speed_d;
  end

  assign speed_o = speed_q;
endmodule

// File: rtl/pm_clkdiv.sv
module pm_clkdiv
  import pm_clkdiv_pkg::*;
#(
  parameter int DIV_RATIO  = 1024,
  parameter int SYNC_STAGE = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pm_wr_i,
  input  logic pm_wdata_i,
  input  logic swb_en_i,
  input  logic irq_pend_i,
  output logic cyc_en_o,
  output logic slow_o,
  output logic pm_ctrl_o
);
  logic   srst_n;
  logic   swb_hit;
  logic   ctrl;
  logic   want_slow;
  logic   tick;
  speed_e speed;

  pm_clkdiv_rstsync #(.STAGES(SYNC_STAGE)) u_rst (
    .clk_i   (clk_i),
    .arst_ni (rst_ni),
    .srst_no (srst_n)
  );

  assign swb_hit   = swb_en_i & irq_pend_i;
  assign want_slow = ctrl & ~swb_hit;

  pm_clkdiv_ctrl u_ctrl (
    .clk_i     (clk_i),
    .rst_ni    (srst_n),
    .wr_i      (pm_wr_i),
    .wdata_i   (pm_wdata_i),
    .swb_hit_i (swb_hit),
    .ctrl_o    (ctrl)
  );

  pm_clkdiv_cnt #(.DIV_RATIO(DIV_RATIO)) u_cnt (
    .clk_i  (clk_i),
    .rst_ni (srst_n),
    .run_i  (speed == SPEED_SLOW),
    .tick_o (tick)
  );

  pm_clkdiv_mode u_mode (
    .clk_i       (clk_i),
    .rst_ni      (srst_n),
    .boundary_i  (tick),
    .want_slow_i (want_slow),
    .speed_o     (speed)
  );

  assign cyc_en_o  = tick;
  assign slow_o    = (speed == SPEED_SLOW);
  assign pm_ctrl_o = ctrl;
endmodule

// File: rtl/pm_clkdiv_chk.sv
module pm_clkdiv_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic swb_en_i,
  input logic irq_pend_i,
  input logic cyc_en_o,
  input logic slow_o,
  input logic pm_ctrl_o
);
  AST_FULL_ALWAYS_EN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !slow_o |-> cyc_en_o); // R2

  AST_SLOW_PULSE_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (slow_o && cyc_en_o) |=> (!cyc_en_o || !slow_o)); // R3

  AST_ENTRY_NEEDS_CTRL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(slow_o) |-> $past(pm_ctrl_o)); // R4

  AST_SWB_CLEARS_CTRL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (swb_en_i && irq_pend_i) |=> !pm_ctrl_o); // R6

  AST_SWB_BLOCKS_ENTRY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (swb_en_i && irq_pend_i && !slow_o) |=> !slow_o); // R8

  AST_CHANGE_AT_BOUNDARY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (slow_o != $past(slow_o)) |-> $past(cyc_en_o)); // R9
endmodule

bind pm_clkdiv pm_clkdiv_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .swb_en_i   (swb_en_i),
  .irq_pend_i (irq_pend_i),
  .cyc_en_o   (cyc_en_o),
  .slow_o     (slow_o),
  .pm_ctrl_o  (pm_ctrl_o)
);

// File: tb/sim_pm_clkdiv.sv
module sim_pm_clkdiv;
  localparam int DIV = 1024;

  logic clk = 1'b0;
  logic rst_n;
  logic wr, wdata, swb_en, irq;
  logic cyc_en, slow, ctrl;
  int   n_pass = 0;
  int   n_fail = 0;

  always #10 clk = ~clk;

  pm_clkdiv #(.DIV_RATIO(DIV)) u0 (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .pm_wr_i    (wr),
    .pm_wdata_i (wdata),
    .swb_en_i   (swb_en),
    .irq_pend_i (irq),
    .cyc_en_o   (cyc_en),
    .slow_o     (slow),
    .pm_ctrl_o  (ctrl)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    if (ok) n_pass++;
    else begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  // Steps until cyc_en is seen high; n = low samples seen before it.
  task automatic wait_pulse(output int n);
    n = 0;
    step();
    while (!cyc_en && n < 3 * DIV) begin
      n++;
      step();
    end
  endtask

  task automatic write_ctrl(input logic v);
    wr = 1'b1; wdata = v;
    step();
    wr = 1'b0; wdata = 1'b0;
  endtask

  task automatic t_reset();
    rst_n = 1'b0; wr = 1'b0; wdata = 1'b0; swb_en = 1'b0; irq = 1'b0;
    repeat (3) step();
    check(cyc_en == 1'b1, "R1", "cyc_en in reset", cyc_en, 1);
    check(slow == 1'b0, "R1", "slow in reset", slow, 0);
    check(ctrl == 1'b0, "R1", "ctrl in reset", ctrl, 0);
    rst_n = 1'b1;
    repeat (4) step();
  endtask

  task automatic t_fast();
    int hi = 0;
    for (int i = 0; i < 20; i++) begin
      step();
      if (cyc_en) hi++;
    end
    check(hi == 20, "R2", "enables in 20 full-speed clocks", hi, 20);
  endtask

  task automatic t_enter();
    int n;
    write_ctrl(1'b1);
    check(ctrl == 1'b1, "R4", "ctrl after write 1", ctrl, 1);
    check(slow == 1'b0, "R4", "slow one clock after write", slow, 0);
    step();
    check(slow == 1'b1, "R4", "slow two clocks after write", slow, 1);
    check(cyc_en == 1'b0, "R4", "first slow clock enable", cyc_en, 0);
    wait_pulse(n);
    check(n + 1 == DIV - 1, "R4", "low clocks before first slow pulse", n + 1, DIV - 1);
    step();
    check(cyc_en == 1'b0, "R3", "pulse width", cyc_en, 0);
    wait_pulse(n);
    check(n + 1 == DIV - 1, "R3", "low clocks between pulses", n + 1, DIV - 1);
  endtask

  task automatic t_swb_off();
    int n;
    swb_en = 1'b0; irq = 1'b1;
    wait_pulse(n);
    check(n == DIV - 1, "R7", "spacing with irq and switchback off", n, DIV - 1);
    check(slow == 1'b1, "R7", "slow with irq and switchback off", slow, 1);
    check(ctrl == 1'b1, "R7", "ctrl with irq and switchback off", ctrl, 1);
    irq = 1'b0;
  endtask

  task automatic t_sw_exit();
    int n;
    repeat (10) step();
    write_ctrl(1'b0);
    check(ctrl == 1'b0, "R5", "ctrl after write 0", ctrl, 0);
    check(slow == 1'b1, "R5", "slow right after write 0", slow, 1);
    wait_pulse(n);
    check(n == DIV - 12, "R9", "mid-cycle exit keeps cycle length", n, DIV - 12);
    check(slow == 1'b1, "R5", "slow at final pulse", slow, 1);
    step();
    check(slow == 1'b0, "R5", "slow after final pulse", slow, 0);
    check(cyc_en == 1'b1, "R5", "enable after exit", cyc_en, 1);
  endtask

  task automatic t_switchback();
    int n;
    write_ctrl(1'b1);
    step();
    check(slow == 1'b1, "R4", "re-entry to slow", slow, 1);
    repeat (100) step();
    swb_en = 1'b1; irq = 1'b1;
    step();
    check(ctrl == 1'b0, "R6", "ctrl cleared by switchback", ctrl, 0);
    check(slow == 1'b1, "R6", "slow until cycle end", slow, 1);
    wait_pulse(n);
    check(n == DIV - 103, "R6", "low clocks until switchback boundary", n, DIV - 103);
    step();
    check(slow == 1'b0, "R6", "full speed after switchback", slow, 0);
    check(cyc_en == 1'b1, "R6", "enable after switchback", cyc_en, 1);
  endtask

  task automatic t_blocked();
    int hi = 0;
    int sl = 0;
    write_ctrl(1'b1);
    check(ctrl == 1'b0, "R8", "ctrl after write 1 during switchback", ctrl, 0);
    for (int i = 0; i < 5; i++) begin
      step();
      if (cyc_en) hi++;
      if (slow) sl++;
    end
    check(sl == 0, "R8", "slow clocks while blocked", sl, 0);
    check(hi == 5, "R8", "enables while blocked", hi, 5);
    swb_en = 1'b0; irq = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_pass, n_pass + n_fail);
    $finish;
  end

  initial begin
    t_reset();
    t_fast();
    t_enter();
    t_swb_off();
    t_sw_exit();
    t_switchback();
    t_blocked();
    $display("%0d/%0d checks passed", n_pass, n_pass + n_fail);
    $finish;
  end
endmodule